// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Queue

This block sits at the front of a core whose instructions are one, two or three 16-bit halfwords long. It fetches aligned 32-bit words from an instruction memory port and places them in an eight-slot halfword buffer. The memory port may take any number of cycles to answer. The block reads the oldest buffered halfword and works out the length of the next instruction from it. It presents that instruction to the decode stage only once every halfword of it is in the buffer.

The buffer is filled a word at a time and drained by whole instructions. In every cycle that the output is valid, the decode stage takes the instruction, and the block removes its halfwords at the next clock edge. When the output is not valid, the decode stage inserts a bubble and nothing is removed. A taken-branch redirect empties the buffer and restarts fetching at the target. The target may point at either halfword of a word. A word fetch that is still outstanding when the redirect arrives has its data thrown away when it returns.

Top module: `ifq_top`

## Requirements
- R1: While reset is held low, `ins_valid_o` is 0. After reset is released, the first word request goes to address `RESET_ADDR`.
- R2: The length comes from bits [15:14] of the head halfword: 2'b11 gives 2 halfwords, 2'b10 gives 3, and any other value gives 1. `ins_len_o` carries the length. `ins_data_o[15:0]` holds the head halfword and `[31:16]` and `[47:32]` hold the following ones.
- R3: The buffer never holds more than `DEPTH` halfwords. A new request is raised only when at least two slots will be free after this cycle's removal and fill.
- R4: `ins_valid_o` is 1 exactly when the buffered halfword count is at least the decoded length. A cycle with `ins_valid_o` at 0 removes nothing.
- R5: Instructions come out in program order. `ins_pc_o` advances by twice the length of each instruction taken.
- R6: At most one fetch is outstanding at a time, and a response may come any number of cycles after its request. Requests without a redirect between them go to consecutive word addresses.
- R7: A cycle with `redirect_i` high empties the buffer, so `ins_valid_o` is 0 in the following cycle. Fetching restarts at the word that holds the target. The first instruction taken after the redirect carries the target's halfword address on `ins_pc_o`.
- R8: If a fetch is outstanding when a redirect arrives, the returned word is discarded and no new request is raised until it has returned. A response in the redirect cycle itself is also discarded.
- R9: When target bit 1 is set, the lower halfword of the first word returned after the redirect is dropped.
- R10: Halfwords beyond the decoded length read as zero in `ins_data_o`, and the whole of `ins_data_o` is zero when `ins_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_i | input | 1 | Taken branch: flush the queue and refetch |
| redirect_addr_i | input | AW | Branch target byte address (bit 0 ignored) |
| mem_req_o | output | 1 | Word fetch request, accepted in the cycle it is high |
| mem_addr_o | output | AW | Word-aligned fetch address |
| mem_rvalid_i | input | 1 | Fetched word is on `mem_rdata_i` |
| mem_rdata_i | input | 32 | Fetched word, earlier halfword in [15:0] |
| ins_valid_o | output | 1 | A whole instruction is presented and is taken this cycle |
| ins_len_o | output | 2 | Instruction length in halfwords (1 to 3) |
| ins_data_o | output | 48 | Instruction halfwords, head in [15:0] |
| ins_pc_o | output | AW | Byte address of the head halfword |

## Verification
The main function is driven with a mix of lengths and with streams where every instruction has the same length. All one-halfword instructions drain the queue slowest, so the buffer fills and the request throttle is exposed. All three-halfword instructions drain it fastest, so instructions straddle word boundaries and the valid flag is withheld while a word is still pending. Each pattern runs under no waitstates, a fixed long stall and irregular stalls, which separates the cases where the buffer limits fetching from those where the memory does. Redirect streams at several rates land on targets of both halfword parities. Some redirects arrive while a fetch is outstanding and some arrive on every cycle, which exercises the odd-target drop and the discard of stale responses.

// File: rtl/ifq_pkg.sv
// Shared types and the instruction-length rule for the prefetch queue.
package ifq_pkg;
    localparam int HWW = 16;

    typedef logic [HWW-1:0] hword_t;

    typedef enum logic [1:0] {
        ILEN_ONE   = 2'd1,
        ILEN_TWO   = 2'd2,
        ILEN_THREE = 2'd3
    } ilen_e;

    // Length of the instruction that starts with the given halfword (R2)
    function automatic ilen_e ilen_of(hword_t head);
        case (head[15:14])
            2'b11:   return ILEN_TWO;
            2'b10:   return ILEN_THREE;
            default: return ILEN_ONE;
        endcase
    endfunction
endpackage

// File: rtl/ifq_len_decode.sv
// Length decoder: maps the head halfword to an instruction length of 1..3.
// Assumes: the length is fully determined by the top two bits of the head.
module ifq_len_decode
    import ifq_pkg::*;
(
    input  hword_t     head_i,
    output logic [1:0] len_o
);
    ilen_e len_e;

    // Purpose: apply the shared length rule
    always_comb begin
        len_e = ilen_of(head_i);
        len_o = len_e;
    end
endmodule

// File: rtl/ifq_hw_buffer.sv
// Circular halfword buffer: takes 0..2 halfwords per cycle at the tail and
// releases 0..3 halfwords per cycle at the head; shows the three oldest.
// Assumes: DEPTH is a power of two and at least 4; the caller never pushes
// past capacity nor pops more than is held.
module ifq_hw_buffer
    import ifq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic [1:0]                 push_cnt_i,
    input  hword_t                     push_hw0_i,
    input  hword_t                     push_hw1_i,
    input  logic [1:0]                 pop_cnt_i,
    output logic [3*HWW-1:0]           peek_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    hword_t          slot_q [DEPTH];
    logic [PW-1:0]   head_q;
    logic [PW-1:0]   tail_q;
    logic [CW-1:0]   level_q;

    // Purpose: store incoming halfwords at the tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (!flush_i) begin
            if (push_cnt_i != 2'd0) slot_q[tail_q] <= push_hw0_i;
            if (push_cnt_i == 2'd2) slot_q[tail_q + PW'(1)] <= push_hw1_i;
        end
    end

    // Purpose: advance head, tail and fill level; a flush empties the buffer
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            head_q  <= '0;
            tail_q  <= '0;
            level_q <= '0;
        end else begin
            head_q  <= head_q + PW'(pop_cnt_i);
            tail_q  <= tail_q + PW'(push_cnt_i);
            level_q <= level_q + CW'(push_cnt_i) - CW'(pop_cnt_i);
        end
    end

    // Purpose: expose the three oldest halfwords
    for (genvar g = 0; g < 3; g++) begin : g_peek
        assign peek_o[g*HWW +: HWW] = slot_q[head_q + PW'(g)];
    end

    assign level_o = level_q;
endmodule

// File: rtl/ifq_fetch_ctrl.sv
// Fetch sequencer: issues word requests, keeps one fetch in flight, marks
// a response stale after a redirect, and remembers whether the first word
// after an odd-halfword target must lose its lower half.
// Assumes: the memory answers each request exactly once, in order.
module ifq_fetch_ctrl #(
    parameter int            AW         = 32,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect_i,
    input  logic [AW-1:0] redirect_addr_i,
    input  logic          room_ok_i,
    input  logic          rvalid_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic          accept_o,
    output logic          drop_low_o
);
    logic          busy_q;
    logic          stale_q;
    logic          drop_low_q;
    logic [AW-1:0] faddr_q;

    // Purpose: request when idle (or freed this cycle) and the buffer has room
    assign req_o    = !redirect_i && room_ok_i && (!busy_q || rvalid_i);
    // Purpose: a response is kept only if it belongs to the current stream
    assign accept_o = rvalid_i && busy_q && !stale_q && !redirect_i;

    // Purpose: track the in-flight fetch, the stale mark and the fetch address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            stale_q    <= 1'b0;
            drop_low_q <= 1'b0;
            faddr_q    <= RESET_ADDR;
        end else if (redirect_i) begin
            faddr_q    <= {redirect_addr_i[AW-1:2], 2'b00};
            drop_low_q <= redirect_addr_i[1];
            busy_q     <= busy_q && !rvalid_i;
            stale_q    <= busy_q && !rvalid_i;
        end else begin
            if (req_o)         busy_q <= 1'b1;
            else if (rvalid_i) busy_q <= 1'b0;
            if (rvalid_i)      stale_q <= 1'b0;
            if (accept_o)      drop_low_q <= 1'b0;
            if (req_o)         faddr_q <= faddr_q + AW'(4);
        end
    end

    assign addr_o     = faddr_q;
    assign drop_low_o = drop_low_q;
endmodule

// File: rtl/ifq_top.sv
// Prefetch queue top: joins the fetch sequencer, the halfword buffer and the
// length decoder. Presents a whole instruction with its address whenever
// it is fully buffered; the consumer takes it in that same cycle.
// Assumes: RESET_ADDR is word aligned; DEPTH is a power of two, at least 4.
module ifq_top
    import ifq_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            DEPTH      = 8,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect_i,
    input  logic [AW-1:0] redirect_addr_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_rvalid_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          ins_valid_o,
    output logic [1:0]    ins_len_o,
    output logic [47:0]   ins_data_o,
    output logic [AW-1:0] ins_pc_o
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int NW = CW + 1;

    logic [CW-1:0]    buf_level;
    logic [3*HWW-1:0] peek;
    logic [1:0]       head_len;
    logic [1:0]       push_cnt;
    logic [1:0]       pop_cnt;
    hword_t           push_hw0;
    hword_t           push_hw1;
    logic             accept;
    logic             drop_low;
    logic             room_ok;
    logic             take;
    logic [NW-1:0]    next_level;
    logic [AW-1:0]    head_pc_q;

    ifq_len_decode u_len (
        .head_i (peek[HWW-1:0]),
        .len_o  (head_len)
    );

    ifq_hw_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (redirect_i),
        .push_cnt_i (push_cnt),
        .push_hw0_i (push_hw0),
        .push_hw1_i (push_hw1),
        .pop_cnt_i  (pop_cnt),
        .peek_o     (peek),
        .level_o    (buf_level)
    );

    ifq_fetch_ctrl #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
        .clk             (clk),
        .rst_n           (rst_n),
        .redirect_i      (redirect_i),
        .redirect_addr_i (redirect_addr_i),
        .room_ok_i       (room_ok),
        .rvalid_i        (mem_rvalid_i),
        .req_o           (mem_req_o),
        .addr_o          (mem_addr_o),
        .accept_o        (accept),
        .drop_low_o      (drop_low)
    );

    // Purpose: valid once every halfword of the head instruction is held (R4)
    assign ins_valid_o = {1'b0, buf_level} >= NW'(head_len);
    assign take        = ins_valid_o && !redirect_i;
    assign pop_cnt     = take ? head_len : 2'd0;
    assign ins_len_o   = head_len;

    // Purpose: select halfwords of an accepted word, dropping the low one after an odd target (R9)
    assign push_cnt = accept ? (drop_low ? 2'd1 : 2'd2) : 2'd0;
    assign push_hw0 = drop_low ? mem_rdata_i[31:16] : mem_rdata_i[15:0];
    assign push_hw1 = mem_rdata_i[31:16];

    // Purpose: allow a request only if two slots stay free after this cycle (R3)
    assign next_level = {1'b0, buf_level} + NW'(push_cnt) - NW'(pop_cnt);
    assign room_ok    = next_level <= NW'(DEPTH - 2);

    // Purpose: address of the head halfword, moved by redirects and takes (R5, R7)
    always_ff @(posedge clk) begin
        if (!rst_n)          head_pc_q <= RESET_ADDR;
        else if (redirect_i) head_pc_q <= {redirect_addr_i[AW-1:1], 1'b0};
        else if (take)       head_pc_q <= head_pc_q + AW'({head_len, 1'b0});
    end
    assign ins_pc_o = head_pc_q;

    // Purpose: present only the halfwords that belong to the instruction (R10)
    for (genvar g = 0; g < 3; g++) begin : g_out
        assign ins_data_o[g*HWW +: HWW] =
            (ins_valid_o && (head_len > 2'(g))) ? peek[g*HWW +: HWW] : '0;
    end
endmodule

// File: rtl/ifq_checker.sv
// Property checker for the prefetch queue, bound into every ifq_top.
// Assumes: it sees the buffer fill level in addition to the ports.
module ifq_checker #(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       redirect_i,
    input logic                       mem_req_o,
    input logic                       mem_rvalid_i,
    input logic                       ins_valid_o,
    input logic [1:0]                 ins_len_o,
    input logic [47:0]                ins_data_o,
    input logic [AW-1:0]              ins_pc_o,
    input logic [$clog2(DEPTH+1)-1:0] fill_level
);
    localparam int CW = $clog2(DEPTH+1);

    logic in_flight;
    logic [1:0] exp_len;

    // Purpose: independent record of whether a fetch awaits its response
    always_ff @(posedge clk) begin
        if (!rst_n)            in_flight <= 1'b0;
        else if (mem_req_o)    in_flight <= 1'b1;
        else if (mem_rvalid_i) in_flight <= 1'b0;
    end

    // Purpose: length expected from the presented head halfword
    always_comb begin
        case (ins_data_o[15:14])
            2'b11:   exp_len = 2'd2;
            2'b10:   exp_len = 2'd3;
            default: exp_len = 2'd1;
        endcase
    end

    a_r6_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && !mem_rvalid_i) |-> !mem_req_o);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (!ins_valid_o && fill_level == '0));

    a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_o && !redirect_i) |=>
            (ins_pc_o == $past(ins_pc_o) + AW'({$past(ins_len_o), 1'b0})));

    a_r2_len_code: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_o |-> (ins_len_o == exp_len));

    a_r4_whole_instr: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_o |-> (fill_level >= CW'(ins_len_o)));

    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_o && ins_len_o == 2'd1) |-> (ins_data_o[47:16] == '0));
endmodule

bind ifq_top ifq_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .redirect_i   (redirect_i),
    .mem_req_o    (mem_req_o),
    .mem_rvalid_i (mem_rvalid_i),
    .ins_valid_o  (ins_valid_o),
    .ins_len_o    (ins_len_o),
    .ins_data_o   (ins_data_o),
    .ins_pc_o     (ins_pc_o),
    .fill_level   (buf_level)
);

// File: tb/ifq_top_tb.sv
// Bench: behavioural memory with waitstates and a queue-based reference
// model of the prefetch queue, compared with the design every cycle.
module ifq_top_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          redirect;
    logic [AW-1:0] redirect_addr;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [31:0]   mem_rdata;
    logic          ins_valid;
    logic [1:0]    ins_len;
    logic [47:0]   ins_data;
    logic [AW-1:0] ins_pc;

    always #2 clk = ~clk;   // 250 MHz

    ifq_top #(.AW(AW), .DEPTH(8), .RESET_ADDR('0)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .redirect_i      (redirect),
        .redirect_addr_i (redirect_addr),
        .mem_req_o       (mem_req),
        .mem_addr_o      (mem_addr),
        .mem_rvalid_i    (mem_rvalid),
        .mem_rdata_i     (mem_rdata),
        .ins_valid_o     (ins_valid),
        .ins_len_o       (ins_len),
        .ins_data_o      (ins_data),
        .ins_pc_o        (ins_pc)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    logic [15:0] q[$];
    logic [31:0] m_pc    = 32'h0;
    logic [31:0] m_faddr = 32'h0;
    bit m_busy = 0, m_disc = 0, m_drop = 0;
    bit fresh = 0, fresh_odd = 0, stale_hit = 0, prev_redir = 0, first_req = 1;

    // bench memory state
    bit          b_pend = 0;
    int          b_wait = 0;
    logic [31:0] b_addr = '0;
    int          cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    function automatic logic [15:0] hw_at(input logic [31:0] a, input int lm);
        logic [15:0] v;
        v = 16'(a[15:0] * 16'h9E37) ^ 16'h3C5A ^ {5'b0, a[15:5]};
        case (lm)
            1: v[15:14] = 2'b00;
            2: v[15:14] = 2'b10;
            3: v[15:14] = 2'b11;
            default: ;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a, input int lm);
        return {hw_at(a + 32'd2, lm), hw_at(a, lm)};
    endfunction

    function automatic int wait_for(input int mode, input int c);
        case (mode)
            0:       return 0;
            1:       return (c * 5) % 4;
            2:       return 3;
            default: return (c % 7 == 0) ? 6 : 1;
        endcase
    endfunction

    function automatic int len_of(input logic [15:0] h);
        if (h[15:14] == 2'b11) return 2;
        if (h[15:14] == 2'b10) return 3;
        return 1;
    endfunction

    // One cycle of the reference model: compare outputs, then advance state
    task automatic model_step();
        int len, popn, pushn, nxt;
        bit v, acc, ereq;
        logic [47:0] ei;
        string tag;
        len = (q.size() > 0) ? len_of(q[0]) : 1;
        v   = q.size() >= len;
        chk(ins_valid === v, prev_redir ? "R7" : "R4", "valid", 64'(ins_valid), 64'(v));
        if (v) begin
            ei  = {(len >= 3) ? q[2] : 16'h0, (len >= 2) ? q[1] : 16'h0, q[0]};
            tag = fresh ? (stale_hit ? "R8" : (fresh_odd ? "R9" : "R7")) : "R2";
            chk(ins_data === ei, tag, "data", 64'(ins_data), 64'(ei));
            chk(ins_len === 2'(len), "R2", "len", 64'(ins_len), 64'(len));
            chk(ins_pc === m_pc, fresh ? tag : "R5", "pc", 64'(ins_pc), 64'(m_pc));
        end else begin
            chk(ins_data === 48'h0, "R10", "idle data", 64'(ins_data), 64'h0);
        end
        acc   = mem_rvalid && m_busy && !m_disc && !redirect;
        pushn = acc ? (m_drop ? 1 : 2) : 0;
        popn  = (v && !redirect) ? len : 0;
        nxt   = q.size() - popn + pushn;
        ereq  = !redirect && (nxt <= 6) && (!m_busy || mem_rvalid);
        chk(mem_req === ereq, (m_busy && !mem_rvalid) ? "R6" : "R3", "req",
            64'(mem_req), 64'(ereq));
        if (ereq)
            chk(mem_addr === m_faddr, first_req ? "R1" : "R6", "addr",
                64'(mem_addr), 64'(m_faddr));
        if (redirect) begin
            q.delete();
            m_pc      = {redirect_addr[31:1], 1'b0};
            m_faddr   = {redirect_addr[31:2], 2'b00};
            m_drop    = redirect_addr[1];
            m_disc    = m_busy && !mem_rvalid;
            m_busy    = m_disc;
            fresh     = 1;
            fresh_odd = redirect_addr[1];
            stale_hit = 0;
        end else begin
            if (v) begin
                for (int k = 0; k < popn; k++) void'(q.pop_front());
                m_pc  = m_pc + 32'(2 * popn);
                fresh = 0;
            end
            if (acc) begin
                if (m_drop) q.push_back(mem_rdata[31:16]);
                else begin
                    q.push_back(mem_rdata[15:0]);
                    q.push_back(mem_rdata[31:16]);
                end
                m_drop = 0;
            end
            if (mem_rvalid && m_busy && m_disc) stale_hit = 1;
            if (mem_rvalid) m_disc = 0;
            m_busy = ereq ? 1'b1 : (mem_rvalid ? 1'b0 : m_busy);
            if (ereq) m_faddr = m_faddr + 32'd4;
        end
        if (ereq) first_req = 0;
        prev_redir = redirect;
    endtask

    task automatic run_phase(input int n, input int wmode, input int lm, input int rper);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n         = 1'b1;
            redirect      = (rper != 0) && ((cyc % rper) == rper - 1);
            redirect_addr = 32'h100 + 32'(cyc * 6);
            if (b_pend && b_wait == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = word_at(b_addr, lm);
                b_pend     = 0;
            end else begin
                mem_rvalid = 1'b0;
                mem_rdata  = 32'hDEADBEEF;
                if (b_pend) b_wait--;
            end
            #1;
            model_step();
            if (mem_req) begin
                b_pend = 1;
                b_addr = mem_addr;
                b_wait = wait_for(wmode, cyc);
            end
            cyc++;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        rst_n         = 1'b0;
        redirect      = 1'b0;
        redirect_addr = '0;
        mem_rvalid    = 1'b0;
        mem_rdata     = '0;
        // R1: no valid output while reset is held
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            chk(ins_valid === 1'b0, "R1", "valid in reset", 64'(ins_valid), 64'h0);
        end
        run_phase(300, 0, 0, 0);   // mixed lengths, no waitstates
        run_phase(400, 1, 0, 0);   // irregular waitstates
        run_phase(200, 2, 2, 0);   // all three-halfword, long stall
        run_phase(200, 0, 1, 0);   // all one-halfword: buffer fills (R3)
        run_phase(200, 3, 3, 0);   // all two-halfword, bursty stalls
        run_phase(400, 1, 0, 9);   // redirects, both target parities (R7, R9)
        run_phase(300, 2, 0, 4);   // redirects while fetch pending (R8)
        run_phase(100, 0, 0, 1);   // redirect every cycle
        run_phase(200, 3, 0, 0);   // recovery stream
        summary();
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        summary();
        $finish;
    end
endmodule